// File: doc/BRIEF.md
# Configuration Register File with Base Address Decoding

This block is the configuration-space target of a single-function peripheral. A host reaches it one byte at a time. Each access carries a function number, an 8-bit register offset and, for writes, a data byte. The block keeps only the few writable fields it needs: the two space-enable bits of the command register, a 4 KB memory window base, a 64-port I/O window base, and the base and enable bit of a 32 KB expansion ROM window. Every other byte of the 256-byte space reads as a fixed value, and each writable byte applies its own mask.

From the stored fields the block produces the window bases and enables that the rest of the chip uses to claim traffic. It also compares incoming memory and I/O addresses against those windows to produce hit flags. Read data comes back one cycle after the read strobe. A write reaches the decoded outputs one cycle after the strobe.

Top module: `pcfg_target`

## Requirements
- R1: After reset, offsets 0x00-0x03 read the vendor ID (low byte first) followed by the device ID. Offset 0x14 reads 0x01. Offsets 0x04, 0x0E, 0x10-0x13 and 0x30-0x33 read 0x00. The enables mem_en, io_en and rom_en are all 0.
- R2: A read with a function number other than 0 returns 0xFF. A write with a function number other than 0 changes no register and no output.
- R3: At offset 0x04, bit 1 is the memory-space enable and bit 0 is the I/O-space enable. Bits 7:2 always read 0.
- R4: Offset 0x10 always reads 0. Offset 0x11 keeps only bits 7:4. Offsets 0x12-0x13 are fully writable. Writing all ones to 0x10-0x13 reads back 0xFFFFF000, and mem_base equals that value.
- R5: A write to 0x14 stores only bits 7:6, and bit 0 always reads 1. Offset 0x15 is fully writable. Offsets 0x16-0x17 ignore writes and read 0. Writing all ones reads back 0x0000FFC1, and io_base is 0xFFC0.
- R6: At 0x30, only bit 0 (the ROM enable) is writable. Offset 0x31 keeps only bit 7. Offsets 0x32-0x33 are fully writable. Writing all ones reads back 0xFFFF8001, and rom_base is 0xFFFF8000.
- R7: mem_en equals the memory-space enable. mem_hit is 1 exactly when mem_en is 1 and mem_addr[31:12] equals mem_base[31:12].
- R8: io_en is 1 only when the I/O-space enable is set and io_base is nonzero. io_hit is 1 exactly when io_en is 1 and io_addr[15:6] equals io_base[15:6].
- R9: rom_en is 1 only when both the ROM enable bit and the memory-space enable are set. rom_hit is 1 exactly when rom_en is 1 and mem_addr[31:15] equals rom_base[31:15].
- R10: The ID bytes, offset 0x0E and all unimplemented offsets ignore writes and keep their fixed values.
- R11: cfg_rvalid is high for exactly one cycle, in the cycle after each cfg_rd strobe, and cfg_rdata is valid in that cycle.
- R12: A write that changes a window base or enable shows on the decoded outputs in the cycle after the write strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_func | input | 3 | Function number of the access |
| cfg_off | input | 8 | Register offset |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data byte |
| cfg_rvalid | output | 1 | Read data valid |
| mem_addr | input | 32 | Memory address to test against the memory and ROM windows |
| io_addr | input | 16 | I/O address to test against the I/O window |
| mem_base | output | 32 | Decoded memory window base |
| mem_en | output | 1 | Memory window enabled |
| io_base | output | 16 | Decoded I/O window base |
| io_en | output | 1 | I/O window enabled |
| rom_base | output | 32 | Decoded ROM window base |
| rom_en | output | 1 | ROM window enabled |
| mem_hit | output | 1 | mem_addr falls in the memory window |
| io_hit | output | 1 | io_addr falls in the I/O window |
| rom_hit | output | 1 | mem_addr falls in the ROM window |

## Verification
The hardest situation to reach is the I/O window with its space bit set but its base masked to zero. Writing 0x3F to offset 0x14 looks like a nonzero base, yet the mask drops every one of those bits. The stimulus first enables I/O space with a live base, then clears the base through such masked bytes, and confirms that io_en falls while the command bits still read 0x03. The ROM gating is exercised the same way: the command register is toggled while the ROM enable bit stays set, so each of the two conditions is seen closing the window on its own.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int ADDR_W    = 32;
    localparam int IO_W      = 16;
    localparam int FUNC_W    = 3;
    localparam int OFF_W     = 8;
    localparam int MEM_ALIGN = 12;
    localparam int IO_ALIGN  = 6;
    localparam int ROM_ALIGN = 15;

    // Writable configuration state only; everything else is constant.
    typedef struct packed {
        logic                         mem_space;
        logic                         io_space;
        logic [ADDR_W-1:MEM_ALIGN]    mbar;
        logic [IO_W-1:IO_ALIGN]       iobar;
        logic                         rom_on;
        logic [ADDR_W-1:ROM_ALIGN]    rombar;
    } cfg_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              en;
    } mwin_t;

    typedef struct packed {
        logic [IO_W-1:0] base;
        logic            en;
    } iowin_t;

    function automatic logic [7:0] cfg_read_byte(
        input cfg_state_t     s,
        input logic [OFF_W-1:0] off,
        input logic [15:0]    vid,
        input logic [15:0]    did
    );
        logic [7:0] v;
        case (off)
            8'h00:   v = vid[7:0];
            8'h01:   v = vid[15:8];
            8'h02:   v = did[7:0];
            8'h03:   v = did[15:8];
            8'h04:   v = {6'b0, s.mem_space, s.io_space};
            8'h11:   v = {s.mbar[15:12], 4'h0};
            8'h12:   v = s.mbar[23:16];
            8'h13:   v = s.mbar[31:24];
            8'h14:   v = {s.iobar[7:6], 5'b0, 1'b1};
            8'h15:   v = s.iobar[15:8];
            8'h30:   v = {7'b0, s.rom_on};
            8'h31:   v = {s.rombar[15], 7'b0};
            8'h32:   v = s.rombar[23:16];
            8'h33:   v = s.rombar[31:24];
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pcfg_regs.sv
module pcfg_regs
    import pcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h7E10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output cfg_state_t        st
);

    logic fn0;
    assign fn0 = (func == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            rdata  <= 8'h00;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd)
                rdata <= fn0 ? cfg_read_byte(st, off, VENDOR_ID, DEVICE_ID) : 8'hFF;
            if (wr && fn0) begin
                case (off)
                    8'h04: begin
                        st.mem_space <= wdata[1];
                        st.io_space  <= wdata[0];
                    end
                    8'h11: st.mbar[15:12]   <= wdata[7:4];
                    8'h12: st.mbar[23:16]   <= wdata;
                    8'h13: st.mbar[31:24]   <= wdata;
                    8'h14: st.iobar[7:6]    <= wdata[7:6];
                    8'h15: st.iobar[15:8]   <= wdata;
                    8'h30: st.rom_on        <= wdata[0];
                    8'h31: st.rombar[15]    <= wdata[7];
                    8'h32: st.rombar[23:16] <= wdata;
                    8'h33: st.rombar[31:24] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);                                          // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rvalid);                                        // R11
    AST_BADFUNC_FF: assert property (@(posedge clk) disable iff (rst)
        (rd && !fn0) |=> (rdata == 8'hFF));                      // R2
    AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && fn0 && off == 8'h04) |=> (rdata[7:2] == 6'b0));   // R3
    AST_IOBAR_TYPE_BIT: assert property (@(posedge clk) disable iff (rst)
        (rd && fn0 && off == 8'h14) |=> rdata[0]);               // R5

endmodule

// File: rtl/pcfg_window.sv
module pcfg_window #(
    parameter int W   = 32,
    parameter int LSB = 12
) (
    input  logic [W-1:0] base,
    input  logic         en,
    input  logic [W-1:0] addr,
    output logic         hit
);
    assign hit = en && (addr[W-1:LSB] == base[W-1:LSB]);
endmodule

// File: rtl/pcfg_decode.sv
module pcfg_decode
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_state_t        st,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [IO_W-1:0]   io_addr,
    output mwin_t             mem_win,
    output iowin_t            io_win,
    output mwin_t             rom_win,
    output logic              mem_hit,
    output logic              io_hit,
    output logic              rom_hit
);

    always_comb begin
        mem_win.base = {st.mbar, {MEM_ALIGN{1'b0}}};
        mem_win.en   = st.mem_space;
        io_win.base  = {st.iobar, {IO_ALIGN{1'b0}}};
        io_win.en    = st.io_space && (st.iobar != '0);
        rom_win.base = {st.rombar, {ROM_ALIGN{1'b0}}};
        rom_win.en   = st.rom_on && st.mem_space;
    end

    pcfg_window #(.W(ADDR_W), .LSB(MEM_ALIGN)) u_mem_cmp (
        .base(mem_win.base), .en(mem_win.en), .addr(mem_addr), .hit(mem_hit));
    pcfg_window #(.W(IO_W), .LSB(IO_ALIGN)) u_io_cmp (
        .base(io_win.base), .en(io_win.en), .addr(io_addr), .hit(io_hit));
    pcfg_window #(.W(ADDR_W), .LSB(ROM_ALIGN)) u_rom_cmp (
        .base(rom_win.base), .en(rom_win.en), .addr(mem_addr), .hit(rom_hit));

    AST_MEMHIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> mem_win.en);                                 // R7
    AST_IO_BASE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        io_win.en |-> (io_win.base != '0));                      // R8
    AST_IOHIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> io_win.en);                                   // R8
    AST_ROM_NEEDS_MEMSPACE: assert property (@(posedge clk) disable iff (rst)
        rom_win.en |-> mem_win.en);                              // R9

endmodule

// File: rtl/pcfg_target.sv
module pcfg_target
    import pcfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h7E10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [OFF_W-1:0]  cfg_off,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              cfg_rvalid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [IO_W-1:0]   io_addr,
    output logic [ADDR_W-1:0] mem_base,
    output logic              mem_en,
    output logic [IO_W-1:0]   io_base,
    output logic              io_en,
    output logic [ADDR_W-1:0] rom_base,
    output logic              rom_en,
    output logic              mem_hit,
    output logic              io_hit,
    output logic              rom_hit
);

    cfg_state_t st;
    mwin_t      mem_win;
    mwin_t      rom_win;
    iowin_t     io_win;

    pcfg_regs #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .rd(cfg_rd), .func(cfg_func),
        .off(cfg_off), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .rvalid(cfg_rvalid), .st(st));

    pcfg_decode u_dec (
        .clk(clk), .rst(rst), .st(st), .mem_addr(mem_addr), .io_addr(io_addr),
        .mem_win(mem_win), .io_win(io_win), .rom_win(rom_win),
        .mem_hit(mem_hit), .io_hit(io_hit), .rom_hit(rom_hit));

    assign mem_base = mem_win.base;
    assign mem_en   = mem_win.en;
    assign io_base  = io_win.base;
    assign io_en    = io_win.en;
    assign rom_base = rom_win.base;
    assign rom_en   = rom_win.en;

    AST_FOREIGN_WR_INERT: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_func != '0) |=> ($stable(mem_base) && $stable(io_base) &&
                                        $stable(rom_base) && $stable(mem_en) &&
                                        $stable(io_en) && $stable(rom_en)));  // R2
    AST_RESET_CLOSED: assert property (@(posedge clk)
        rst |=> (!mem_en && !io_en && !rom_en));                               // R1

endmodule

// File: tb/pcfg_target_tb_top.sv
module pcfg_target_tb_top;

    localparam logic [15:0] VID = 16'hA5C3;
    localparam logic [15:0] DID = 16'h7E10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_off = '0, cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cfg_rvalid;
    logic [31:0] mem_addr = '0;
    logic [15:0] io_addr = '0;
    logic [31:0] mem_base, rom_base;
    logic [15:0] io_base;
    logic        mem_en, io_en, rom_en, mem_hit, io_hit, rom_hit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    pcfg_target #(.VENDOR_ID(VID), .DEVICE_ID(DID)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_func(cfg_func), .cfg_off(cfg_off), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .mem_addr(mem_addr),
        .io_addr(io_addr), .mem_base(mem_base), .mem_en(mem_en),
        .io_base(io_base), .io_en(io_en), .rom_base(rom_base), .rom_en(rom_en),
        .mem_hit(mem_hit), .io_hit(io_hit), .rom_hit(rom_hit));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each returned byte against the scoreboard head (R11)
    always @(negedge clk) begin
        if (!rst && cfg_rvalid) begin
            if (q_exp.size() == 0) begin
                check("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(q_tag.pop_front(), {24'h0, cfg_rdata}, {24'h0, q_exp.pop_front()});
            end
        end
    end

    task automatic wr(input logic [7:0] off, input logic [7:0] d, input logic [2:0] fn = 3'd0);
        cfg_wr = 1'b1; cfg_func = fn; cfg_off = off; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_func = 3'd0;
    endtask

    task automatic rd(input logic [7:0] off, input logic [7:0] exp, input string tag,
                      input logic [2:0] fn = 3'd0);
        cfg_rd = 1'b1; cfg_func = fn; cfg_off = off;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(posedge clk); #1;
        cfg_rd = 1'b0; cfg_func = 3'd0;
    endtask

    task automatic wr32(input logic [7:0] off, input logic [31:0] d);
        for (int i = 0; i < 4; i++) wr(off + 8'(i), d[8*i +: 8]);
    endtask

    task automatic rd32(input logic [7:0] off, input logic [31:0] exp, input string tag);
        for (int i = 0; i < 4; i++) rd(off + 8'(i), exp[8*i +: 8], tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1: reset state
        rd32(8'h00, {DID, VID}, "R1 ids");
        rd(8'h04, 8'h00, "R1 cmd");
        rd(8'h0E, 8'h00, "R1 header type");
        rd32(8'h10, 32'h0, "R1 mem bar");
        rd32(8'h14, 32'h1, "R1 io bar");
        rd32(8'h30, 32'h0, "R1 rom reg");
        check("R1 mem_en", mem_en, 0);
        check("R1 io_en", io_en, 0);
        check("R1 rom_en", rom_en, 0);

        // R12: enable memory space; outputs change only after the edge
        cfg_wr = 1'b1; cfg_off = 8'h04; cfg_wdata = 8'h02; #1;
        check("R12 mem_en before edge", mem_en, 0);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        check("R12 mem_en after edge", mem_en, 1);

        // R3: command mask
        wr(8'h04, 8'hFF);
        rd(8'h04, 8'h03, "R3 cmd mask");

        // R4/R5/R6: sizing with all ones
        wr32(8'h10, 32'hFFFF_FFFF);
        rd32(8'h10, 32'hFFFF_F000, "R4 mem bar size");
        check("R4 mem_base", mem_base, 32'hFFFF_F000);
        wr32(8'h14, 32'hFFFF_FFFF);
        rd32(8'h14, 32'h0000_FFC1, "R5 io bar size");
        check("R5 io_base", io_base, 16'hFFC0);
        check("R8 io_en live base", io_en, 1);
        wr32(8'h30, 32'hFFFF_FFFF);
        rd32(8'h30, 32'hFFFF_8001, "R6 rom size");
        check("R6 rom_base", rom_base, 32'hFFFF_8000);
        check("R9 rom_en both set", rom_en, 1);

        // R9: each condition closes the ROM window alone
        wr(8'h04, 8'h01);
        check("R9 rom_en mem space off", rom_en, 0);
        check("R7 mem_en off", mem_en, 0);
        mem_addr = 32'hFFFF_F123; #1;
        check("R7 mem_hit gated", mem_hit, 0);
        check("R9 rom_hit gated", rom_hit, 0);
        wr(8'h04, 8'h03);
        mem_addr = 32'hFFFF_8004; #1;
        check("R9 rom_hit", rom_hit, 1);
        wr(8'h30, 8'h00);
        check("R9 rom_en enable bit off", rom_en, 0);
        check("R9 rom_hit enable off", rom_hit, 0);

        // R7: memory window compare
        wr32(8'h10, 32'h1234_5ABC);
        check("R7 mem_base", mem_base, 32'h1234_5000);
        mem_addr = 32'h1234_5FFF; #1;
        check("R7 hit top", mem_hit, 1);
        mem_addr = 32'h1234_6000; #1;
        check("R7 miss above", mem_hit, 0);
        mem_addr = 32'h1234_4FFF; #1;
        check("R7 miss below", mem_hit, 0);

        // R8: masked-zero base keeps the I/O window closed
        wr(8'h15, 8'h00);
        wr(8'h14, 8'h3F);
        rd(8'h04, 8'h03, "R8 cmd still set");
        check("R8 io_en zero base", io_en, 0);
        io_addr = 16'h0000; #1;
        check("R8 io_hit zero base", io_hit, 0);
        wr(8'h15, 8'h03);
        io_addr = 16'h033F; #1;
        check("R8 io_hit inside", io_hit, 1);
        io_addr = 16'h0340; #1;
        check("R8 io_hit outside", io_hit, 0);
        wr(8'h04, 8'h02);
        io_addr = 16'h0300; #1;
        check("R8 io_hit space off", io_hit, 0);

        // R2: foreign function
        wr(8'h04, 8'h00, 3'd1);
        wr(8'h13, 8'h00, 3'd5);
        check("R2 mem_en unchanged", mem_en, 1);
        check("R2 mem_base unchanged", mem_base, 32'h1234_5000);
        rd(8'h00, 8'hFF, "R2 read func1", 3'd1);
        rd(8'h04, 8'hFF, "R2 read func7", 3'd7);
        rd(8'h13, 8'h12, "R2 func0 byte intact");

        // R10: read-only bytes
        wr(8'h00, 8'h00);
        wr(8'h03, 8'h00);
        wr(8'h0E, 8'h80);
        wr(8'h3C, 8'h5A);
        wr(8'h10, 8'hFF);
        wr(8'h16, 8'hFF);
        rd(8'h00, VID[7:0], "R10 vid low");
        rd(8'h03, DID[15:8], "R10 did high");
        rd(8'h0E, 8'h00, "R10 header type");
        rd(8'h3C, 8'h00, "R10 unimplemented");
        rd(8'h10, 8'h00, "R4 byte 0x10 read-only");
        rd(8'h16, 8'h00, "R5 byte 0x16 ignored");

        repeat (3) @(posedge clk); #1;
        check("R11 scoreboard drained", q_exp.size(), 0);
        finish_run();
    end

endmodule